// File: doc/BRIEF.md
# Addressable Sink-Output Latch Bank

This block keeps a bank of output switches, eight by default, each either ON (the output pulls its line low and sinks current) or OFF. A binary address picks one output. A serial data bit gives the value for that output. Two control inputs, both active low, choose how the bank reacts on each clock edge:

- A write into the picked output.
- A hold of every output.
- A decode, where only the picked output may be ON.
- A clear of the whole bank.

Outside logic uses the bank as a cheap way to drive many loads from a few wires. With the enable input high, the address can change freely without disturbing the outputs. A single-cycle enable pulse then commits one bit. The block samples its inputs on a system clock, so every change appears at the outputs one clock after the edge that sampled it.

Two views of the same state are provided. One is an ON/OFF vector, where 1 means the output sinks. The other is a pin-level vector, which is the logical inverse of the first.

Top module: `addr_sink_latch`

## Requirements
- R1: While reset (`rst_ni` low, asynchronous) is asserted, and after it is released, every output is OFF: `on_o` is all zeros and `pin_o` is all ones.
- R2: Write mode is selected by `clr_ni`=1 and `en_ni`=0. At a clock edge in this mode, bit `addr_i` of `on_o` takes `data_i`, with 1 meaning ON. Every other bit keeps its value.
- R3: Hold mode is selected by `clr_ni`=1 and `en_ni`=1. At a clock edge in this mode, `on_o` is unchanged, whatever `data_i` and `addr_i` do, including when the address moves on every cycle.
- R4: Decode mode is selected by `clr_ni`=0 and `en_ni`=0. At a clock edge in this mode, bit `addr_i` of `on_o` takes `data_i` and every other bit becomes 0 (OFF).
- R5: Clear mode is selected by `clr_ni`=0 and `en_ni`=1. At a clock edge in this mode, every bit of `on_o` becomes 0, whatever `data_i` and `addr_i` are.
- R6: `pin_o` is at all times the bitwise inverse of `on_o`, so an ON output shows a low pin level.
- R7: After a clear, moving to hold mode (`clr_ni` raised while `en_ni` stays 1) keeps every output OFF. After a decode, moving to hold mode keeps the single decoded output and leaves the rest OFF.
- R8: Every output change appears exactly one clock edge after the edge that sampled the inputs causing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; inputs are sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; forces all outputs OFF |
| addr_i | input | ADDR_W (3) | Binary index of the output being addressed |
| data_i | input | 1 | Serial data bit; 1 turns the addressed output ON |
| en_ni | input | 1 | Active-low enable; high blocks writes |
| clr_ni | input | 1 | Active-low clear; low selects decode or clear mode |
| on_o | output | NUM_OUT (8) | Per-output state, 1 = ON (sinking) |
| pin_o | output | NUM_OUT (8) | Per-output pin level, inverse of `on_o` |

## Verification
Writes of alternating ones and zeros to every address, in ascending and then descending order, show whether each address reaches its own bit and leaves its neighbours untouched. Runs in hold mode sweep the address and toggle data on every cycle. They tell a correct hold apart from a hold that leaks writes through. Decode steps placed on top of a populated bank separate decode from a plain write, because stale ON bits must disappear. Clear followed by hold shows that the OFF state persists. A long pseudo-random mix of all four modes is then compared against a behavioural model on every clock.

// File: rtl/sink_latch_pkg.sv
package sink_latch_pkg;

    // Mode code is the concatenation {clr_n, en_n}.
    typedef enum logic [1:0] {
        MODE_DECODE = 2'b00,
        MODE_CLEAR  = 2'b01,
        MODE_WRITE  = 2'b10,
        MODE_HOLD   = 2'b11
    } bank_mode_e;

    function automatic bank_mode_e mode_of(input logic clr_n, input logic en_n);
        return bank_mode_e'({clr_n, en_n});
    endfunction

endpackage

// File: rtl/sink_mode_select.sv
module sink_mode_select
    import sink_latch_pkg::*;
(
    input  logic       clr_ni,
    input  logic       en_ni,
    output bank_mode_e mode_o,
    output logic       wr_sel_o,
    output logic       wipe_o
);

    always_comb begin
        mode_o = mode_of(clr_ni, en_ni);
        // wr_sel_o: the addressed bit is loaded from data
        wr_sel_o = (mode_o == MODE_WRITE) || (mode_o == MODE_DECODE);
        // wipe_o: the bits that are not addressed are forced OFF
        wipe_o = (mode_o == MODE_DECODE) || (mode_o == MODE_CLEAR);
    end

endmodule

// File: rtl/sink_addr_onehot.sv
module sink_addr_onehot #(
    parameter int NUM_OUT = 8,
    parameter int ADDR_W  = 3
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [NUM_OUT-1:0] sel_o
);

    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_sel
        assign sel_o[gi] = (addr_i == ADDR_W'(gi));
    end

endmodule

// File: rtl/addr_sink_latch.sv
module addr_sink_latch
    import sink_latch_pkg::*;
#(
    parameter int NUM_OUT = 8,
    localparam int ADDR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               data_i,
    input  logic               en_ni,
    input  logic               clr_ni,
    output logic [NUM_OUT-1:0] on_o,
    output logic [NUM_OUT-1:0] pin_o
);

    typedef struct packed {
        logic [NUM_OUT-1:0] on;
    } bank_state_t;

    bank_state_t        state_d, state_q;
    bank_mode_e         mode;
    logic               wr_sel;
    logic               wipe;
    logic [NUM_OUT-1:0] sel;

    sink_mode_select u_mode (
        .clr_ni   (clr_ni),
        .en_ni    (en_ni),
        .mode_o   (mode),
        .wr_sel_o (wr_sel),
        .wipe_o   (wipe)
    );

    sink_addr_onehot #(
        .NUM_OUT (NUM_OUT),
        .ADDR_W  (ADDR_W)
    ) u_sel (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    // Next-state: each bit is loaded from data, forced OFF or kept.
    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (wr_sel && sel[i]) begin
                state_d.on[i] = data_i;
            end else if (wipe) begin
                state_d.on[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign on_o  = state_q.on;
    assign pin_o = ~state_q.on;

    logic unused_mode;
    assign unused_mode = ^mode;

endmodule

// File: rtl/addr_sink_latch_chk.sv
module addr_sink_latch_chk #(
    parameter int NUM_OUT = 8,
    parameter int ADDR_W  = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               data_i,
    input logic               en_ni,
    input logic               clr_ni,
    input logic [NUM_OUT-1:0] on_o,
    input logic [NUM_OUT-1:0] pin_o
);

    // R1: bank is empty whenever reset is held at a clock edge
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            assert_reset_off_R1: assert (on_o == '0);
        end
    end

    // R2: a write only touches the addressed bit
    assert_write_isolated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_ni && !en_ni) |=>
            ((on_o ^ $past(on_o)) & ~(NUM_OUT'(1) << $past(addr_i))) == '0);

    // R2: the addressed bit takes the data value
    assert_write_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_ni && !en_ni) |=> (on_o[$past(addr_i)] == $past(data_i)));

    // R3: hold mode freezes the bank
    assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_ni && en_ni) |=> $stable(on_o));

    // R4: decode leaves at most one output ON, and only the addressed one
    assert_decode_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_ni && !en_ni) |=>
            ($onehot0(on_o) && ((on_o & ~(NUM_OUT'(1) << $past(addr_i))) == '0)));

    // R5: clear empties the bank
    assert_clear_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_ni && en_ni) |=> (on_o == '0));

    // R7: after a clear, hold keeps the bank empty
    assert_clear_then_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_ni && en_ni && on_o == '0) |=> ($countones(on_o) == 0));

endmodule

bind addr_sink_latch addr_sink_latch_chk #(
    .NUM_OUT (NUM_OUT),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .data_i (data_i),
    .en_ni  (en_ni),
    .clr_ni (clr_ni),
    .on_o   (on_o),
    .pin_o  (pin_o)
);

// File: tb/addr_sink_latch_test.sv
`timescale 1ns/1ps
module addr_sink_latch_test;

    localparam int N  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          data = 1'b0;
    logic          en_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [N-1:0]  on, pin;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [N-1:0] model;
    logic [15:0]  lfsr = 16'hACE1;

    always #5 clk = ~clk;

    addr_sink_latch uut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .addr_i (addr),
        .data_i (data),
        .en_ni  (en_n),
        .clr_ni (clr_n),
        .on_o   (on),
        .pin_o  (pin)
    );

    function automatic string req_of(input logic c, input logic e);
        if (c && !e) return "R2";
        if (c && e)  return "R3";
        if (!c && !e) return "R4";
        return "R5";
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (on !== model) begin
            fails++;
            $display("FAIL %s: on actual=%b expected=%b", tag, on, model);
        end
        checks++;
        if (pin !== ~model) begin
            fails++;
            $display("FAIL R6: pin actual=%b expected=%b", pin, ~model);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, update model, compare (R8).
    task automatic step(input logic c, input logic e, input int a, input logic d, input string tag);
        logic [N-1:0] nxt;
        clr_n = c; en_n = e; addr = AW'(a); data = d;
        @(posedge clk);
        nxt = model;
        if (c && !e) begin
            nxt[a] = d;
        end else if (!c && !e) begin
            nxt = '0;
            nxt[a] = d;
        end else if (!c && e) begin
            nxt = '0;
        end
        model = nxt;
        @(negedge clk);
        compare(tag == "" ? req_of(c, e) : tag);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                fails++;
                $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        model = '0;
        @(negedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R2: ascending writes of alternating data
        for (int i = 0; i < N; i++) step(1, 0, i, i[0] ^ 1'b1, "R2");
        // R2: descending writes with opposite data
        for (int i = N - 1; i >= 0; i--) step(1, 0, i, i[0], "R2");
        // R3: address sweep with toggling data under hold
        for (int i = 0; i < 2 * N; i++) step(1, 1, i % N, i[0], "R3");
        // R4: decode over a populated bank
        step(1, 0, 2, 1, "R2");
        step(0, 0, 5, 1, "R4");
        step(1, 1, 1, 1, "R7");
        step(1, 1, 6, 0, "R7");
        step(0, 0, 3, 0, "R4");
        // R5 then R7: clear then hold stays empty
        for (int i = 0; i < N; i++) step(1, 0, i, 1, "R2");
        step(0, 1, 4, 1, "R5");
        step(1, 1, 7, 1, "R7");
        step(1, 1, 0, 1, "R7");

        // Mixed pseudo-random traffic
        for (int k = 0; k < 2000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[1], int'(lfsr[4:2]), lfsr[6], "");
        end

        // R1: asynchronous reset mid-run
        step(1, 0, 3, 1, "R2");
        #2 rst_n = 1'b0;
        #1 model = '0;
        compare("R1");
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule